// File: doc/BRIEF.md
# Two-Channel Action-Table PWM Generator

This block produces two pulse-width-modulated outputs from one shared 16-bit up-counting time base. The counter climbs from zero to the programmed period value and returns to zero on the following clock, so one output period lasts the programmed value plus one clocks. Each channel has a compare value and a six-bit action word. The action word picks what the channel does on three counter events: the counter at zero, the counter equal to the channel's compare value, and the counter equal to the period value. Each event can leave the channel alone, drive it low, drive it high or toggle it.

Software loads every setting through a plain write port (address, data, strobe). Each setting lands first in a shadow copy. The shadow moves into the working copy only at the boundary where the counter returns to zero, so a change never cuts a period short. While the block is disabled, the working copies follow the shadows on every clock. A per-channel force field can pin an output low or high regardless of the action logic.

The time base is a two-state machine. In state `TB_IDLE` the counter is parked at zero and the shadows copy through on every clock. In state `TB_RUN` the counter counts and events fire. The transition `TB_IDLE -> TB_RUN` (start) is taken when `en` is high. The transition `TB_RUN -> TB_IDLE` (stop) is taken when `en` is low. In every other case the state holds.

For a normal-polarity waveform, program the zero event to drive high and the compare event to drive low. For inverted polarity, swap the two. For full duty, set the compare field to no action. For zero duty, set the compare value to 0.

Top module: `pwm_aq_gen`

## Requirements
- R1: After reset, the counter reads 0, both outputs are low, and all shadow and working settings are 0.
- R2: While running, the counter steps by one on each clock up to the working period value P, then returns to 0 on the next clock, so a period is P+1 clocks long. With P = 0xFFFF the counter reaches 0xFFFF before it returns to 0.
- R3: Write addresses: 0 = period; 1 = compare for channel 0; 2 = compare for channel 1; 3 = action word for channel 0; 4 = action word for channel 1; 5 = force word. Action word bit positions: [1:0] zero event, [3:2] compare event, [5:4] period event. Action codes: 00 none, 01 low, 10 high, 11 toggle. Force word: bits [1:0] channel 0, bits [3:2] channel 1.
- R4: An event seen while the counter holds value k changes the channel state on the clock edge that ends that cycle. A toggle action inverts the state.
- R5: When several events coincide, the compare event has the highest priority, then the period event, then the zero event. An event whose field is "none" yields to the next one in that order. With compare value 0 in normal polarity, the duty is 0%.
- R6: A written period, compare, action or force value takes effect only from the clock at which the counter returns to 0 after reaching the working period. While disabled, it takes effect on the next clock.
- R7: Force code 01 holds the output low and code 10 holds it high. Codes 00 and 11 let the output follow the channel state.
- R8: While `en` is low, the counter is held at 0, no events fire and the channel states hold. After `en` rises, the first counting cycle shows counter 0, and its zero event acts on the next edge.
- R9: Both channels run from the same counter and period with independent compare and action settings. A normal channel with compare C is high for C clocks per period, and an inverted channel with compare C is high for P+1-C clocks.
- R10: With the compare field set to none and the zero field set to high, the output stays high for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable for the time base |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Setting address |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Current counter value |
| pwm_out | output | 2 | Channel outputs, bit 0 = channel 0 |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a period. The bench must show that the old period and duty are kept until the counter wraps, and that the new ones appear right after. To get there, the stimulus waits on the counter output until it reaches a chosen value, writes a shorter period, then measures the peak counter value of the current period and of the next one. Event collisions are reached by programming period 0, where the zero and period events fire on every clock together. The longest period is reached by running one full 65536-clock cycle.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    // Per-event action codes
    typedef enum logic [1:0] {
        AQ_NONE   = 2'b00,
        AQ_LOW    = 2'b01,
        AQ_HIGH   = 2'b10,
        AQ_TOGGLE = 2'b11
    } aq_act_e;

    // Time-base state machine
    typedef enum logic {
        TB_IDLE = 1'b0,
        TB_RUN  = 1'b1
    } tb_state_e;

    // Action word: zero event in [1:0], compare in [3:2], period in [5:4]
    typedef struct packed {
        aq_act_e on_prd;
        aq_act_e on_cmp;
        aq_act_e on_zero;
    } aq_word_t;

    localparam int AQ_W  = 6;
    localparam int FRC_W = 2;

endpackage

// File: rtl/pwm_aq_timebase.sv
module pwm_aq_timebase
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] prd_act,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             ev_live,
    output logic             ev_zero,
    output logic             ev_prd,
    output logic             load
);

    tb_state_e        state_q;
    tb_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             at_top;

    assign at_top = (cnt_q == prd_act);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TB_IDLE: if (en)  state_d = TB_RUN;   // start
            TB_RUN:  if (!en) state_d = TB_IDLE;  // stop
            default: state_d = TB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TB_IDLE;
        else        state_q <= state_d;
    end

    // counter next value
    always_comb begin
        cnt_d = '0;
        unique case (state_q)
            TB_IDLE: cnt_d = '0;
            TB_RUN:  begin
                if (!en)         cnt_d = '0;
                else if (at_top) cnt_d = '0;
                else             cnt_d = cnt_q + 1'b1;
            end
            default: cnt_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // outputs
    always_comb begin
        run     = 1'b0;
        ev_live = 1'b0;
        load    = 1'b0;
        unique case (state_q)
            TB_IDLE: begin
                load = 1'b1;
            end
            TB_RUN: begin
                run     = 1'b1;
                ev_live = en;
                load    = en && at_top;
            end
            default: load = 1'b1;
        endcase
    end

    assign ev_zero = ev_live && (cnt_q == '0);
    assign ev_prd  = ev_live && at_top;
    assign cnt     = cnt_q;

endmodule

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NCH    = 2,
    parameter int ADDR_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [CNT_W-1:0]          wr_data,
    input  logic                      load,
    output logic [CNT_W-1:0]          prd_act,
    output logic [NCH-1:0][CNT_W-1:0] cmp_act,
    output aq_word_t [NCH-1:0]        aq_act,
    output logic [NCH*FRC_W-1:0]      frc_act
);

    localparam int A_PRD  = 0;
    localparam int A_CMP0 = 1;
    localparam int A_AQ0  = A_CMP0 + NCH;
    localparam int A_FRC  = A_AQ0 + NCH;
    localparam int FW     = NCH * FRC_W;

    logic [CNT_W-1:0] prd_shd;
    logic [FW-1:0]    frc_shd;
    logic             hit_prd;
    logic             hit_frc;

    assign hit_prd = wr_en && (wr_addr == ADDR_W'(A_PRD));
    assign hit_frc = wr_en && (wr_addr == ADDR_W'(A_FRC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd_shd <= '0;
            prd_act <= '0;
        end else begin
            if (load)    prd_act <= prd_shd;
            if (hit_prd) prd_shd <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frc_shd <= '0;
            frc_act <= '0;
        end else begin
            if (load)    frc_act <= frc_shd;
            if (hit_frc) frc_shd <= wr_data[FW-1:0];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chreg
        logic [CNT_W-1:0] cmp_shd;
        aq_word_t         aq_shd;
        logic             hit_cmp;
        logic             hit_aq;

        assign hit_cmp = wr_en && (wr_addr == ADDR_W'(A_CMP0 + i));
        assign hit_aq  = wr_en && (wr_addr == ADDR_W'(A_AQ0 + i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_shd    <= '0;
                cmp_act[i] <= '0;
            end else begin
                if (load)    cmp_act[i] <= cmp_shd;
                if (hit_cmp) cmp_shd    <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                aq_shd    <= '0;
                aq_act[i] <= '0;
            end else begin
                if (load)   aq_act[i] <= aq_shd;
                if (hit_aq) aq_shd    <= aq_word_t'(wr_data[AQ_W-1:0]);
            end
        end
    end

endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_live,
    input  logic             ev_zero,
    input  logic             ev_prd,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  aq_word_t         aq,
    input  logic [FRC_W-1:0] frc,
    output logic             q,
    output logic             pin
);

    logic    ev_cmp;
    aq_act_e sel;
    logic    q_d;

    assign ev_cmp = ev_live && (cnt == cmp);

    // lowest priority first; later matches override
    always_comb begin
        sel = AQ_NONE;
        if (ev_zero && aq.on_zero != AQ_NONE) sel = aq.on_zero;
        if (ev_prd  && aq.on_prd  != AQ_NONE) sel = aq.on_prd;
        if (ev_cmp  && aq.on_cmp  != AQ_NONE) sel = aq.on_cmp;
    end

    always_comb begin
        q_d = q;
        unique case (sel)
            AQ_NONE:   q_d = q;
            AQ_LOW:    q_d = 1'b0;
            AQ_HIGH:   q_d = 1'b1;
            AQ_TOGGLE: q_d = ~q;
            default:   q_d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_d;
    end

    always_comb begin
        unique case (frc)
            2'b01:   pin = 1'b0;
            2'b10:   pin = 1'b1;
            default: pin = q;
        endcase
    end

endmodule

// File: rtl/pwm_aq_gen.sv
module pwm_aq_gen
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NCH    = 2,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [NCH-1:0]    pwm_out
);

    logic [CNT_W-1:0]          cnt;
    logic                      run;
    logic                      ev_live;
    logic                      ev_zero;
    logic                      ev_prd;
    logic                      load;
    logic [CNT_W-1:0]          prd_act;
    logic [NCH-1:0][CNT_W-1:0] cmp_act;
    aq_word_t [NCH-1:0]        aq_act;
    logic [NCH*FRC_W-1:0]      frc_act;
    logic [NCH-1:0]            chan_q;

    pwm_aq_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .prd_act (prd_act),
        .cnt     (cnt),
        .run     (run),
        .ev_live (ev_live),
        .ev_zero (ev_zero),
        .ev_prd  (ev_prd),
        .load    (load)
    );

    pwm_aq_regs #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (load),
        .prd_act (prd_act),
        .cmp_act (cmp_act),
        .aq_act  (aq_act),
        .frc_act (frc_act)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_aq_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_live (ev_live),
            .ev_zero (ev_zero),
            .ev_prd  (ev_prd),
            .cnt     (cnt),
            .cmp     (cmp_act[i]),
            .aq      (aq_act[i]),
            .frc     (frc_act[i*FRC_W +: FRC_W]),
            .q       (chan_q[i]),
            .pin     (pwm_out[i])
        );
    end

    assign cnt_o = cnt;

endmodule

// File: rtl/pwm_aq_gen_chk.sv
module pwm_aq_gen_chk #(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic                 run,
    input logic [CNT_W-1:0]     cnt,
    input logic [CNT_W-1:0]     prd_act,
    input logic [NCH*CNT_W-1:0] cmp_flat,
    input logic [NCH*6-1:0]     aq_flat,
    input logic [NCH-1:0]       chan_q
);

    logic live;
    assign live = run && en;

    // R2
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cnt == prd_act) |=> (cnt == '0));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cnt != prd_act) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R8
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(chan_q));

    // R6
    prd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cnt != prd_act) |=> $stable(prd_act));

    // R5
    cmp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cnt == cmp_flat[CNT_W-1:0] && aq_flat[3:2] == 2'b01) |=> !chan_q[0]);

endmodule

bind pwm_aq_gen pwm_aq_gen_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .run      (run),
    .cnt      (cnt),
    .prd_act  (prd_act),
    .cmp_flat (cmp_act),
    .aq_flat  (aq_act),
    .chan_q   (chan_q)
);

// File: tb/pwm_aq_gen_test.sv
module pwm_aq_gen_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] cnt_o;
    logic [1:0]  pwm_out;

    int n_checks = 0;
    int n_err = 0;

    pwm_aq_gen uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cnt_o   (cnt_o),
        .pwm_out (pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_run, m_cnt, m_prd_s, m_prd_a, m_frc_s, m_frc_a;
    int m_cmp_s [2];
    int m_cmp_a [2];
    int m_aq_s  [2];
    int m_aq_a  [2];
    int m_q     [2];

    function automatic int fld(input int word, input int pos);
        return (word >> pos) & 3;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_prd_s = 0; m_prd_a = 0; m_frc_s = 0; m_frc_a = 0;
            for (int c = 0; c < 2; c++) begin
                m_cmp_s[c] = 0; m_cmp_a[c] = 0; m_aq_s[c] = 0; m_aq_a[c] = 0; m_q[c] = 0;
            end
        end else begin
            int live, ld, nc, a;
            live = (m_run != 0) && en;
            if (live != 0) begin
                for (int c = 0; c < 2; c++) begin
                    a = 0;
                    if (m_cnt == 0 && fld(m_aq_a[c], 0) != 0)         a = fld(m_aq_a[c], 0);
                    if (m_cnt == m_prd_a && fld(m_aq_a[c], 4) != 0)    a = fld(m_aq_a[c], 4);
                    if (m_cnt == m_cmp_a[c] && fld(m_aq_a[c], 2) != 0) a = fld(m_aq_a[c], 2);
                    if (a == 1) m_q[c] = 0;
                    else if (a == 2) m_q[c] = 1;
                    else if (a == 3) m_q[c] = 1 - m_q[c];
                end
            end
            ld = (m_run == 0) || (live != 0 && m_cnt == m_prd_a);
            nc = (live != 0 && m_cnt != m_prd_a) ? m_cnt + 1 : 0;
            if (ld != 0) begin
                m_prd_a = m_prd_s; m_frc_a = m_frc_s;
                for (int c = 0; c < 2; c++) begin
                    m_cmp_a[c] = m_cmp_s[c]; m_aq_a[c] = m_aq_s[c];
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_prd_s = wr_data;
                    3'd1: m_cmp_s[0] = wr_data;
                    3'd2: m_cmp_s[1] = wr_data;
                    3'd3: m_aq_s[0] = wr_data & 63;
                    3'd4: m_aq_s[1] = wr_data & 63;
                    3'd5: m_frc_s = wr_data & 15;
                    default: ;
                endcase
            end
            m_cnt = nc;
            m_run = en;
        end
    end

    function automatic int exp_pin(input int c);
        int f;
        f = (m_frc_a >> (2*c)) & 3;
        if (f == 1) return 0;
        if (f == 2) return 1;
        return m_q[c];
    endfunction

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 counter", int'(cnt_o), m_cnt);
            check("R4 pin0", int'(pwm_out[0]), exp_pin(0));
            check("R4 pin1", int'(pwm_out[1]), exp_pin(1));
        end
    end

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int h0, output int h1);
        h0 = 0; h1 = 0;
        repeat (n) begin
            @(negedge clk);
            h0 += int'(pwm_out[0]);
            h1 += int'(pwm_out[1]);
        end
    endtask

    initial begin
        cycles(CLK_PERIOD * 19000);
        n_checks++; n_err++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        int h0, h1, mx, n, p0;
        cycles(3);
        check("R1 reset counter", int'(cnt_o), 0);
        check("R1 reset outputs", int'(pwm_out), 0);
        rst_n = 1'b1;
        cycles(2);
        check("R1 idle outputs", int'(pwm_out), 0);

        // R3 R9 R10: normal on channel 0, inverted on channel 1
        wr(0, 9); wr(1, 3); wr(2, 4); wr(3, 6); wr(4, 9);
        @(negedge clk) en = 1'b1;
        cycles(25);
        count_high(10, h0, h1);
        check("R3 R9 normal duty ch0", h0, 3);
        check("R9 inverted duty ch1", h1, 6);

        // R10 full duty: compare field none
        wr(3, 2);
        cycles(25);
        count_high(10, h0, h1);
        check("R10 full duty", h0, 10);

        // R5 zero duty: compare 0 beats zero event
        wr(3, 6); wr(1, 0);
        cycles(25);
        count_high(10, h0, h1);
        check("R5 zero duty", h0, 0);

        // R7 force
        wr(1, 3);
        wr(5, 1);
        cycles(25);
        count_high(10, h0, h1);
        check("R7 force low", h0, 0);
        check("R7 ch1 unforced", h1, 6);
        wr(5, 2);
        cycles(25);
        count_high(10, h0, h1);
        check("R7 force high", h0, 10);
        wr(5, 3);
        cycles(25);
        count_high(10, h0, h1);
        check("R7 code 11 follows", h0, 3);
        wr(5, 0);

        // R6 shadowed period change mid-period
        do @(negedge clk); while (cnt_o != 16'd2);
        wr(0, 4);
        mx = 0;
        do begin @(negedge clk); if (int'(cnt_o) > mx) mx = int'(cnt_o); end while (cnt_o != 16'd0);
        check("R6 old period kept", mx, 9);
        mx = 0;
        do begin @(negedge clk); if (int'(cnt_o) > mx) mx = int'(cnt_o); end while (cnt_o != 16'd0);
        check("R6 new period applied", mx, 4);

        // R4 toggle on zero, period 5 clocks
        wr(3, 3);
        cycles(25);
        count_high(10, h0, h1);
        check("R4 toggle duty", h0, 5);

        // R5 period beats zero with period 0
        @(negedge clk) en = 1'b0;
        wr(0, 0); wr(1, 5); wr(3, 8'h21);
        @(negedge clk) en = 1'b1;
        cycles(5);
        check("R5 period over zero high", int'(pwm_out[0]), 1);
        wr(3, 8'h12);
        cycles(5);
        check("R5 period over zero low", int'(pwm_out[0]), 0);

        // R8 enable low holds state
        wr(0, 2); wr(3, 3);
        cycles(12);
        @(negedge clk);
        p0 = int'(pwm_out[0]);
        en = 1'b0;
        repeat (6) begin
            @(negedge clk);
            check("R8 counter parked", int'(cnt_o), 0);
            check("R8 output held", int'(pwm_out[0]), p0);
        end
        en = 1'b1;
        cycles(2);
        check("R8 restart counter", int'(cnt_o), 1);
        check("R8 restart zero event", int'(pwm_out[0]), 1 - p0);

        // R2 longest period
        @(negedge clk) en = 1'b0;
        wr(0, 16'hFFFF);
        @(negedge clk) en = 1'b1;
        do @(negedge clk); while (cnt_o != 16'd1);
        n = 0; mx = 0;
        do begin @(negedge clk); n++; if (int'(cnt_o) > mx) mx = int'(cnt_o); end while (cnt_o != 16'd0);
        check("R2 max count", mx, 65535);
        check("R2 max period length", n, 65535);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule